// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the storage and steering half of a 32-bit processor that spends several clock cycles on each instruction. It holds the program counter, the instruction register, a memory data register, two operand latches, an ALU result register and a register file. One ALU and one memory port are reused in every step of an instruction. The holding registers carry values from one cycle to the next, and multiplexers choose what feeds the ALU, the memory address and the register write port.

A separate sequencer drives the enable strobes and select fields on every cycle. The datapath returns the opcode of the held instruction and the ALU zero flag so that the sequencer can pick its next step. The instruction mix is add, sub, and, or, set-less-than, load word, store word, branch-on-equal and jump. Instruction fields sit at fixed positions:

- opcode in bits 31:26
- first source in 25:21
- second source in 20:16
- R-type destination in 15:11
- immediate in 15:0
- jump index in 25:0
- function code in 5:0

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the PC, IR, MDR, both operand latches, the ALU result register and every register-file entry to zero on the next rising edge.
- R2: `mem_addr` equals the PC when `addr_sel`=0 and the ALU result register when `addr_sel`=1.
- R3: `opb_sel` picks the second ALU operand. The encodings are 00 for the B latch, 01 for the constant 4, 10 for the sign-extended IR[15:0], and 11 for that sign-extended value shifted left by two.
- R4: `opa_sel`=0 feeds the PC to the first ALU operand, and `opa_sel`=1 feeds the A latch.
- R5: `alu_mode` 00 adds and 01 subtracts. `alu_mode` 10 decodes the function code IR[5:0] as follows: 32 is add, 34 is sub, 36 is bitwise and, 37 is bitwise or, and 42 is signed set-less-than, which gives 1 or 0. The internal operation codes are and=000, or=001, add=010, sub=110 and slt=111.
- R6: On every edge, A loads register IR[25:21] and B loads register IR[20:16]. `mem_wdata` always presents B.
- R7: With `rf_wr`=1, the write goes to register IR[15:11] if `dst_sel`=1, otherwise to IR[20:16]. The write data is the ALU result register if `wb_sel`=0 and the MDR if `wb_sel`=1.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: IR loads `mem_rdata` only when `ir_wr`=1 and otherwise holds. The MDR and the ALU result register reload on every edge.
- R10: The PC loads when `pc_wr`=1, or when `pc_wr_cond`=1 and `zero`=1. Its source is set by `pc_sel`: 00 (and 11) takes the live ALU output, 01 takes the ALU result register, and 10 takes {PC[31:28], IR[25:0], 2'b00}.
- R11: `zero` is 1 exactly when the live ALU output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 32 | Read data from the shared memory |
| mem_addr | output | 32 | Byte address to the shared memory |
| mem_wdata | output | 32 | Store data (B latch) |
| pc_wr | input | 1 | Unconditional PC load |
| pc_wr_cond | input | 1 | PC load gated by zero |
| ir_wr | input | 1 | Instruction register load |
| addr_sel | input | 1 | Memory address source |
| rf_wr | input | 1 | Register-file write enable |
| dst_sel | input | 1 | Write register field select |
| wb_sel | input | 1 | Write-back data source |
| opa_sel | input | 1 | First ALU operand select |
| opb_sel | input | 2 | Second ALU operand select |
| alu_mode | input | 2 | ALU control mode |
| pc_sel | input | 2 | PC source select |
| opcode | output | 6 | IR[31:26] |
| zero | output | 1 | Live ALU result is zero |

## Verification
The bench acts as the sequencer and runs a short program through the block. That program covers every arithmetic function code, a load of a negative word, a store, a branch that is not taken and one that is taken, a jump, and a write to register 0.

- A signed set-less-than done as an unsigned compare returns the wrong bit for the negative operand.
- A PC gated without the zero flag would execute the words that the taken branch skips, and those words contain a store.
- A register 0 that accepts writes feeds 14 instead of 0 into the next add.
- An IR that loads without its enable changes the opcode during an idle cycle.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int XLEN = 32;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG  = 2'b00,
        OPB_FOUR = 2'b01,
        OPB_IMM  = 2'b10,
        OPB_IMM4 = 2'b11
    } opb_sel_e;

    typedef enum logic [1:0] {
        PCS_ALU  = 2'b00,
        PCS_OUT  = 2'b01,
        PCS_JUMP = 2'b10,
        PCS_RSVD = 2'b11
    } pc_sel_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] mdr;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] aluout;
    } dp_state_t;

endpackage

// File: rtl/mcd_aluctl.sv
module mcd_aluctl
    import mcd_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [5:0] funct,
    output alu_op_e    op
);
    always_comb begin
        op = ALU_ADD;
        unique case (mode)
            2'b00: op = ALU_ADD;
            2'b01: op = ALU_SUB;
            2'b10: begin
                unique case (funct)
                    6'd32:   op = ALU_ADD;
                    6'd34:   op = ALU_SUB;
                    6'd36:   op = ALU_AND;
                    6'd37:   op = ALU_OR;
                    6'd42:   op = ALU_SLT;
                    default: op = ALU_ADD;
                endcase
            end
            default: op = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
    import mcd_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] res,
    output logic         is_zero
);
    always_comb begin
        unique case (op)
            ALU_AND: res = x & y;
            ALU_OR:  res = x | y;
            ALU_ADD: res = x + y;
            ALU_SUB: res = x - y;
            ALU_SLT: res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))};
            default: res = '0;
        endcase
    end

    assign is_zero = (res == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [NREGS-1:0][W-1:0] word;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign word[i] = '0;
        end else begin : g_store
            logic [W-1:0] val_q;
            logic [W-1:0] val_d;

            always_comb begin
                val_d = val_q;
                if (we && (waddr == AW'(i))) begin
                    val_d = wdata;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    val_q <= '0;
                end else begin
                    val_q <= val_d;
                end
            end

            assign word[i] = val_q;
        end
    end

    assign rdata_a = word[raddr_a];
    assign rdata_b = word[raddr_b];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mcd_pkg::*;
#(
    parameter int NREGS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            pc_wr,
    input  logic            pc_wr_cond,
    input  logic            ir_wr,
    input  logic            addr_sel,
    input  logic            rf_wr,
    input  logic            dst_sel,
    input  logic            wb_sel,
    input  logic            opa_sel,
    input  logic [1:0]      opb_sel,
    input  logic [1:0]      alu_mode,
    input  logic [1:0]      pc_sel,
    output logic [5:0]      opcode,
    output logic            zero
);
    localparam int AW = $clog2(NREGS);

    dp_state_t st_q;
    dp_state_t st_d;

    logic [XLEN-1:0] rd_a;
    logic [XLEN-1:0] rd_b;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] wb_data;
    logic [XLEN-1:0] pc_src;
    logic [AW-1:0]   wr_idx;
    logic            pc_load;
    alu_op_e         alu_op;

    // Instruction field extraction
    assign imm_ext = {{(XLEN-16){st_q.ir[15]}}, st_q.ir[15:0]};
    assign wr_idx  = dst_sel ? AW'(st_q.ir[15:11]) : AW'(st_q.ir[20:16]);
    assign wb_data = wb_sel ? st_q.mdr : st_q.aluout;

    mcd_regfile #(
        .NREGS (NREGS),
        .W     (XLEN)
    ) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_wr),
        .waddr   (wr_idx),
        .wdata   (wb_data),
        .raddr_a (AW'(st_q.ir[25:21])),
        .raddr_b (AW'(st_q.ir[20:16])),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    // Operand steering
    always_comb begin
        opa = opa_sel ? st_q.a : st_q.pc;
        unique case (opb_sel_e'(opb_sel))
            OPB_REG:  opb = st_q.b;
            OPB_FOUR: opb = XLEN'(4);
            OPB_IMM:  opb = imm_ext;
            OPB_IMM4: opb = {imm_ext[XLEN-3:0], 2'b00};
            default:  opb = st_q.b;
        endcase
    end

    mcd_aluctl u_ctl (
        .mode  (alu_mode),
        .funct (st_q.ir[5:0]),
        .op    (alu_op)
    );

    mcd_alu #(
        .W (XLEN)
    ) u_alu (
        .op      (alu_op),
        .x       (opa),
        .y       (opb),
        .res     (alu_y),
        .is_zero (zero)
    );

    // Program counter source
    always_comb begin
        unique case (pc_sel_e'(pc_sel))
            PCS_OUT:  pc_src = st_q.aluout;
            PCS_JUMP: pc_src = {st_q.pc[XLEN-1:XLEN-4], st_q.ir[25:0], 2'b00};
            default:  pc_src = alu_y;
        endcase
    end

    assign pc_load = pc_wr | (pc_wr_cond & zero);

    // Next state
    always_comb begin
        st_d        = st_q;
        st_d.a      = rd_a;
        st_d.b      = rd_b;
        st_d.mdr    = mem_rdata;
        st_d.aluout = alu_y;
        if (ir_wr) begin
            st_d.ir = mem_rdata;
        end
        if (pc_load) begin
            st_d.pc = pc_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr  = addr_sel ? st_q.aluout : st_q.pc;
    assign mem_wdata = st_q.b;
    assign opcode    = st_q.ir[31:26];

    // Views for the bound checker
    logic [XLEN-1:0] chk_pc;
    logic [XLEN-1:0] chk_ir;
    logic [XLEN-1:0] chk_a;
    assign chk_pc = st_q.pc;
    assign chk_ir = st_q.ir;
    assign chk_a  = st_q.a;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk (
    input logic        clk,
    input logic        rst,
    input logic        ir_wr,
    input logic        pc_wr,
    input logic        pc_wr_cond,
    input logic        zero,
    input logic [31:0] mem_rdata,
    input logic [31:0] pc_q,
    input logic [31:0] ir_q,
    input logic [31:0] a_q
);
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc_q == 32'd0));

    a_r9_ir_hold: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(ir_q));

    a_r9_ir_load: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (ir_q == $past(mem_rdata)));

    a_r10_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc_q));

    a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (ir_q[25:21] == 5'd0) |=> (a_q == 32'd0));
endmodule

bind mc_datapath mc_datapath_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ir_wr      (ir_wr),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .zero       (zero),
    .mem_rdata  (mem_rdata),
    .pc_q       (chk_pc),
    .ir_q       (chk_ir),
    .a_q        (chk_a)
);

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic pcw;
        logic pcwc;
        logic irw;
        logic asel;
        logic rfw;
        logic dst;
        logic wb;
        logic opa;
        logic [1:0] opb;
        logic [1:0] mode;
        logic [1:0] psel;
        logic mwe;
    } ctl_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    ctl_t        c = '0;
    logic [31:0] mem [64];
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [5:0]  opcode;
    logic        zero;
    logic        done = 1'b0;
    int          checks = 0;
    int          bad = 0;

    // Reference model state
    logic [31:0] m_pc = 0, m_ir = 0, m_mdr = 0, m_a = 0, m_b = 0, m_out = 0;
    logic [31:0] m_rf [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:2]];

    mc_datapath u_mc_datapath (
        .clk        (clk),
        .rst        (rst),
        .mem_rdata  (mem_rdata),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .pc_wr      (c.pcw),
        .pc_wr_cond (c.pcwc),
        .ir_wr      (c.irw),
        .addr_sel   (c.asel),
        .rf_wr      (c.rfw),
        .dst_sel    (c.dst),
        .wb_sel     (c.wb),
        .opa_sel    (c.opa),
        .opb_sel    (c.opb),
        .alu_mode   (c.mode),
        .pc_sel     (c.psel),
        .opcode     (opcode),
        .zero       (zero)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_alu(input logic [1:0] mode, input logic [5:0] fn,
                                            input logic [31:0] x, input logic [31:0] y);
        if (mode == 2'b01) return x - y;
        if (mode == 2'b10) begin
            case (fn)
                6'd34: return x - y;
                6'd36: return x & y;
                6'd37: return x | y;
                6'd42: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
                default: return x + y;
            endcase
        end
        return x + y;
    endfunction

    // One clock: compare outputs to model, then advance model with the same controls
    task automatic tick();
        logic [31:0] ea, x, y, r, sx, n_pc, n_ir, n_a, n_b;
        logic [4:0]  dst;
        #1;
        ea = c.asel ? m_out : m_pc;
        sx = {{16{m_ir[15]}}, m_ir[15:0]};
        x  = c.opa ? m_a : m_pc;
        case (c.opb)
            2'b00: y = m_b;
            2'b01: y = 32'd4;
            2'b10: y = sx;
            default: y = sx << 2;
        endcase
        r = ref_alu(c.mode, m_ir[5:0], x, y);
        check(mem_addr === ea, "R2 mem_addr", mem_addr, ea);
        check(mem_wdata === m_b, "R6 mem_wdata", mem_wdata, m_b);
        check(opcode === m_ir[31:26], "R9 opcode", {26'd0, opcode}, {26'd0, m_ir[31:26]});
        check(zero === (r == 0), "R11 zero", {31'd0, zero}, {31'd0, r == 0});
        n_pc = m_pc;
        if (c.pcw || (c.pcwc && r == 0)) begin
            case (c.psel)
                2'b01: n_pc = m_out;
                2'b10: n_pc = {m_pc[31:28], m_ir[25:0], 2'b00};
                default: n_pc = r;
            endcase
        end
        n_ir = c.irw ? mem[ea[7:2]] : m_ir;
        n_a  = m_rf[m_ir[25:21]];
        n_b  = m_rf[m_ir[20:16]];
        if (c.rfw) begin
            dst = c.dst ? m_ir[15:11] : m_ir[20:16];
            if (dst != 0) m_rf[dst] = c.wb ? m_mdr : m_out;
        end
        m_mdr = mem[ea[7:2]];
        m_out = r;
        m_pc  = n_pc;
        m_ir  = n_ir;
        m_a   = n_a;
        m_b   = n_b;
        @(negedge clk);
        if (c.mwe) mem[ea[7:2]] = n_b == n_b ? mem_wdata_hold : mem_wdata_hold;
    endtask

    logic [31:0] mem_wdata_hold;
    always @(posedge clk) mem_wdata_hold <= mem_wdata;

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] itype(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic expect_pc(input logic [31:0] v, input string tag);
        c = '0;
        #1;
        check(mem_addr === v, tag, mem_addr, v);
    endtask

    // Runs one instruction the way a sequencer would; exp_r is the R-type result
    task automatic run_instr(input logic [31:0] exp_r, input string tag);
        c = '0; c.irw = 1; c.pcw = 1; c.opb = 2'b01; tick();
        c = '0; c.opb = 2'b11; tick();
        case (m_ir[31:26])
            6'd35: begin
                c = '0; c.opa = 1; c.opb = 2'b10; tick();
                c = '0; c.asel = 1; tick();
                c = '0; c.rfw = 1; c.wb = 1; tick();
            end
            6'd43: begin
                c = '0; c.opa = 1; c.opb = 2'b10; tick();
                c = '0; c.asel = 1; c.mwe = 1; tick();
            end
            6'd4: begin
                c = '0; c.opa = 1; c.mode = 2'b01; c.pcwc = 1; c.psel = 2'b01; tick();
            end
            6'd2: begin
                c = '0; c.pcw = 1; c.psel = 2'b10; tick();
            end
            default: begin
                c = '0; c.opa = 1; c.mode = 2'b10; tick();
                c = '0; c.asel = 1; c.rfw = 1; c.dst = 1;
                #1;
                check(mem_addr === exp_r, tag, mem_addr, exp_r);
                tick();
            end
        endcase
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'd0;
        for (int i = 0; i < 32; i++) m_rf[i] = 32'd0;
        mem[0]  = itype(35, 0, 1, 'hC0);
        mem[1]  = itype(35, 0, 2, 'hC4);
        mem[2]  = rtype(1, 2, 3, 32);
        mem[3]  = rtype(1, 2, 4, 34);
        mem[4]  = rtype(1, 2, 5, 36);
        mem[5]  = rtype(1, 2, 6, 37);
        mem[6]  = rtype(2, 1, 7, 42);
        mem[7]  = rtype(1, 2, 8, 42);
        mem[8]  = itype(43, 0, 3, 'hC8);
        mem[9]  = itype(4, 1, 2, 5);
        mem[10] = itype(4, 3, 3, 3);
        mem[11] = itype(43, 0, 1, 'hD0);
        mem[12] = itype(43, 0, 1, 'hD0);
        mem[13] = itype(43, 0, 1, 'hD0);
        mem[14] = rtype(1, 1, 0, 32);
        mem[15] = rtype(0, 1, 10, 32);
        mem[16] = {6'd2, 26'd20};
        mem[17] = itype(43, 0, 1, 'hD0);
        mem[20] = itype(43, 0, 10, 'hCC);
        mem[48] = 32'd7;
        mem[49] = 32'hFFFF_FFFD;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(mem_addr === 32'd0, "R1 reset pc", mem_addr, 32'd0);
        check(mem_wdata === 32'd0, "R1 reset B", mem_wdata, 32'd0);
        check(opcode === 6'd0, "R1 reset IR", {26'd0, opcode}, 32'd0);
        @(negedge clk);

        run_instr(0, "R7 lw");
        run_instr(0, "R7 lw");
        run_instr(32'd4, "R5 add");
        run_instr(32'd10, "R5 sub");
        run_instr(32'd5, "R5 and");
        run_instr(32'hFFFF_FFFF, "R5 or");
        run_instr(32'd1, "R5 slt signed true");
        run_instr(32'd0, "R5 slt signed false");
        run_instr(0, "R7 sw");
        // Idle cycle: memory at PC holds a branch word, IR must keep the store
        c = '0; tick();
        check(opcode === 6'd43, "R9 IR held without ir_wr", {26'd0, opcode}, 32'd43);
        run_instr(0, "R10 beq not taken");
        expect_pc(32'd40, "R10 not-taken branch falls through");
        run_instr(0, "R10 beq taken");
        expect_pc(32'd56, "R10 taken branch target (R3 shifted immediate)");
        run_instr(32'd14, "R8 write to r0 aluout");
        run_instr(32'd7, "R8 r0 reads zero after write");
        run_instr(0, "R10 jump");
        expect_pc(32'd80, "R10 jump target");
        run_instr(0, "R6 sw r10");
        check(mem[50] === 32'd4, "R7 stored add result", mem[50], 32'd4);
        check(mem[51] === 32'd7, "R8 stored r10", mem[51], 32'd7);
        check(mem[52] === 32'd0, "R10 skipped stores", mem[52], 32'd0);
        check(mem[49] === 32'hFFFF_FFFD, "R4 data untouched", mem[49], 32'hFFFF_FFFD);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog R1 act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule